// File: doc/BRIEF.md
# Constant-Rate Time-Base Tick Generator

This block runs on a programmable PLL clock whose frequency is chosen by a 3-bit code, and it produces two enables for the converter logic. The first is a conversion-clock enable that is high on two of every three PLL cycles, which gives two thirds of the PLL rate (2.0 MHz when the PLL runs at its nominal 3.0 MHz). The second is a one-cycle tick strobe at an average of 32.768 kHz. This rate stays the same for every code, so timers built on the tick do not care how fast the PLL is running.

The tick comes from a phase accumulator. The accumulator advances only on conversion-enabled cycles, and its increment is chosen by the frequency code. Each increment is computed at elaboration from the PLL frequency for its code, so no table is written out by hand. A new code is not used at once. It is taken in only on the cycle that a tick fires. The accumulator remainder carries over across the change, so no tick is dropped or doubled when the code moves.

Top module: `tbase_tick_gen`

## Requirements
- R1: While the active-low reset is asserted, and on the first cycle after it is released, `conv_en` is 1 and `tick` is 0. The 3-cycle phase, the accumulator and the active code (0) are all cleared.
- R2: Counting from reset release, `conv_en` repeats the pattern 1, 1, 0 on successive PLL cycles.
- R3: On each rising edge where `conv_en` is 1, the 32-bit accumulator adds the active increment. When this addition wraps past 2^32, `tick` is 1 for the following cycle. The accumulator does not change on other edges.
- R4: The increment for code c is round(32768 * 3 * 2^32 / (2 * f(c))), where f(c) = 3,000,000 + c * 500,000 Hz.
- R5: `tick` is never high on two consecutive cycles.
- R6: `freq_code` is sampled only on an edge where the accumulator wraps, and the increment for that code is used from the next addition onward. Changes of `freq_code` at any other time have no effect on `tick` until that edge.
- R7: A code change keeps the accumulator remainder. Nothing is cleared at the tick boundary.
- R8: With a constant code, the number of ticks counted over N PLL cycles is within one of N * 32768 / f(c).
- R9: An asynchronous reset asserted in mid-run returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Programmable PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq_code | input | 3 | PLL frequency code, selects the accumulator increment |
| conv_en | output | 1 | Conversion clock enable, two of every three cycles |
| tick | output | 1 | One-cycle time-base strobe, 32.768 kHz average |

## Verification
Two events can land on the same cycle: an accumulator wrap and a change of the frequency code. The code is sampled only at the wrap. The bench's reference model predicts the wrap one half-cycle ahead, and the bench then drives a new code at exactly that point. This checks that the new increment is taken in at the tick edge and used from the next addition onward. Every cycle, the model's `conv_en` and `tick` are compared with the design, so a code that is taken in one edge early or one edge late shows up as a shifted tick.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Rounded accumulator increment so that carries occur at tick_hz when the
  // accumulator advances on two of every three cycles of a clock at f_hz.
  function automatic longint unsigned calc_inc(
    input longint unsigned tick_hz,
    input longint unsigned f_hz,
    input int              acc_w
  );
    longint unsigned num;
    longint unsigned den;
    num = (tick_hz * 64'd3) << acc_w;
    den = 64'd2 * f_hz;
    return (num + den / 64'd2) / den;
  endfunction

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_IDLE = 2'd2
  } conv_phase_e;

endpackage

// File: rtl/conv_phase_gen.sv
module conv_phase_gen
  import tbase_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic conv_en
);

  conv_phase_e phase_q;
  conv_phase_e phase_d;

  always_comb begin
    case (phase_q)
      PH_A:    phase_d = PH_B;
      PH_B:    phase_d = PH_IDLE;
      default: phase_d = PH_A;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_A;
    else        phase_q <= phase_d;
  end

  assign conv_en = (phase_q != PH_IDLE);

  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q inside {PH_A, PH_B, PH_IDLE});

  assert_gap_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> conv_en);

endmodule

// File: rtl/tick_inc_select.sv
module tick_inc_select
  import tbase_pkg::*;
#(
  parameter int              CODE_W      = 3,
  parameter int              ACC_W       = 32,
  parameter longint unsigned TICK_HZ     = 32768,
  parameter longint unsigned PLL_BASE_HZ = 3000000,
  parameter longint unsigned PLL_STEP_HZ = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] freq_code,
  input  logic              load,
  output logic [ACC_W-1:0]  inc
);

  localparam int NCODES = 1 << CODE_W;

  logic [ACC_W-1:0]  inc_tab [NCODES];
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  for (genvar gi = 0; gi < NCODES; gi++) begin : g_inc
    localparam longint unsigned FREQ = PLL_BASE_HZ + longint'(gi) * PLL_STEP_HZ;
    localparam longint unsigned VAL  = calc_inc(TICK_HZ, FREQ, ACC_W);
    assign inc_tab[gi] = ACC_W'(VAL);
  end

  always_comb begin
    code_d = code_q;
    if (load) code_d = freq_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign inc = inc_tab[code_q];

  assert_code_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(inc));

endmodule

// File: rtl/tick_phase_acc.sv
module tick_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic             wrap,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   sum;
  logic             tick_q;
  logic             tick_d;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, inc};
    wrap   = en & sum[ACC_W];
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (en) begin
      acc_d  = sum[ACC_W-1:0];
      tick_d = sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  assert_tick_on_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(en));

  assert_acc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/tbase_tick_gen.sv
module tbase_tick_gen #(
  parameter int              CODE_W      = 3,
  parameter int              ACC_W       = 32,
  parameter longint unsigned TICK_HZ     = 32768,
  parameter longint unsigned PLL_BASE_HZ = 3000000,
  parameter longint unsigned PLL_STEP_HZ = 500000
) (
  input  logic              clk_pll,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] freq_code,
  output logic              conv_en,
  output logic              tick
);

  logic             en_w;
  logic             wrap_w;
  logic [ACC_W-1:0] inc_w;

  conv_phase_gen u_phase (
    .clk     (clk_pll),
    .rst_n   (rst_n),
    .conv_en (en_w)
  );

  tick_inc_select #(
    .CODE_W      (CODE_W),
    .ACC_W       (ACC_W),
    .TICK_HZ     (TICK_HZ),
    .PLL_BASE_HZ (PLL_BASE_HZ),
    .PLL_STEP_HZ (PLL_STEP_HZ)
  ) u_inc (
    .clk       (clk_pll),
    .rst_n     (rst_n),
    .freq_code (freq_code),
    .load      (wrap_w),
    .inc       (inc_w)
  );

  tick_phase_acc #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk   (clk_pll),
    .rst_n (rst_n),
    .en    (en_w),
    .inc   (inc_w),
    .wrap  (wrap_w),
    .tick  (tick)
  );

  assign conv_en = en_w;

  assert_tick_after_en_R3: assert property (@(posedge clk_pll) disable iff (!rst_n)
    tick |-> !conv_en || $past(conv_en));

endmodule

// File: tb/test_tbase_tick_gen.sv
module test_tbase_tick_gen;

  localparam longint unsigned MOD     = 64'd1 << 32;
  localparam longint unsigned TICK_HZ = 32768;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] freq_code;
  logic       conv_en;
  logic       tick;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  // Reference model state
  int              m_ph   = 0;
  longint unsigned m_acc  = 0;
  int              m_act  = 0;
  bit              m_tick = 0;
  bit              prev_tick = 0;

  tbase_tick_gen i_tbase_tick_gen (
    .clk_pll   (clk),
    .rst_n     (rst_n),
    .freq_code (freq_code),
    .conv_en   (conv_en),
    .tick      (tick)
  );

  always #4 clk = ~clk;

  function automatic longint unsigned f_of(input int c);
    return 64'd3000000 + longint'(c) * 64'd500000;
  endfunction

  function automatic longint unsigned inc_of(input int c);
    longint unsigned den;
    den = 64'd2 * f_of(c);
    return (((TICK_HZ * 64'd3) << 32) + den / 2) / den;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_acc = 0; m_act = 0; m_tick = 0;
    end else begin
      longint unsigned s;
      m_tick = 0;
      if (m_ph != 2) begin
        s = m_acc + inc_of(m_act);
        if (s >= MOD) begin
          m_tick = 1;
          m_act  = int'(freq_code);
          s      = s - MOD;
        end
        m_acc = s;
      end
      m_ph = (m_ph + 1) % 3;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check(conv_en === (m_ph != 2), "R2 conv_en pattern", longint'(conv_en), longint'(m_ph != 2));
      check(tick === m_tick, "R3/R4/R6/R7 tick timing", longint'(tick), longint'(m_tick));
      check(!(tick && prev_tick), "R5 tick single cycle", longint'(tick), 0);
    end
    prev_tick = tick;
  end

  // Drive a new code exactly on the cycle whose next edge wraps (R6/R7 coincidence).
  task automatic hit_wrap(input logic [2:0] c);
    do @(negedge clk); while (!(m_ph != 2 && m_acc + inc_of(m_act) >= MOD));
    freq_code = c;
  endtask

  initial begin
    rst_n = 1'b0;
    freq_code = 3'd5;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    check(conv_en === 1'b1, "R1 conv_en in reset", longint'(conv_en), 1);
    check(tick === 1'b0, "R1 tick in reset", longint'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(conv_en === 1'b1 && tick === 1'b0, "R1 first cycle after reset",
          longint'({conv_en, tick}), 2);

    // Code 0 held until the first tick loads code 5; then steady.
    repeat (3000) @(negedge clk);

    // R6: code wiggles between ticks
    for (int k = 0; k < 540; k++) begin
      freq_code = 3'(k * 3 + 1);
      repeat (37) @(negedge clk);
    end

    // R6/R7: code change coincides with the wrap edge
    for (int k = 0; k < 16; k++) hit_wrap(3'(7 - (k % 8)));
    for (int k = 0; k < 8; k++) begin
      hit_wrap(3'(k));
      @(negedge clk);
      freq_code = 3'(~k);
    end

    // R8: long-run rate with a constant code of 3
    freq_code = 3'd3;
    do @(negedge clk); while (!tick);
    do @(negedge clk); while (!tick);
    begin
      longint cnt = 0;
      longint n   = 60000;
      longint lhs, rhs, diff;
      for (int k = 0; k < 60000; k++) begin
        @(negedge clk);
        if (tick) cnt++;
      end
      lhs  = cnt * longint'(f_of(3));
      rhs  = n * longint'(TICK_HZ);
      diff = (lhs > rhs) ? lhs - rhs : rhs - lhs;
      check(diff <= longint'(f_of(3)), "R8 long-run tick count", cnt, rhs / longint'(f_of(3)));
    end

    // R9: reset in mid-run
    repeat (41) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check(conv_en === 1'b1 && tick === 1'b0, "R9 async reset clears",
          longint'({conv_en, tick}), 2);
    @(negedge clk);
    rst_n = 1'b1;
    freq_code = 3'd6;
    repeat (2000) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule